// File: doc/BRIEF.md
# Opcode-Driven Half-Duplex SPI Master

This block is a half-duplex SPI master run by a small packed program. A host loads a 64-bit program word that holds eight one-byte opcodes. The engine executes them starting with the top byte. Each opcode either picks a chip select, shifts a number of bytes out, shifts a number of bytes in, or ends the program. The byte count of a shift, or the select index, sits in the low nibble of the opcode.

Outgoing data comes from a 64-bit transmit word register, and incoming data collects in a 64-bit receive word register. Each of these registers has a full flag that the host polls. The host refills or drains them in eight-byte chunks. A status word shows the sequencer state one-hot, the full flags, sticky overrun and underrun flags, and program errors. A clock configuration register holds the SCK divider and also carries a two-write abort sequence.

Top module: `seqspi_engine`

## Requirements
- R1: The host port maps these registers: program at address 0, clock configuration at 1, transmit word at 2, receive word at 3, status at 4. The program is accepted only while the engine is idle. Its opcodes run from bits 63:56 downward. Opcode 0x00 ends the program, and after the eighth opcode the engine always returns to idle. The status field in bits 55:48 is one-hot: 0x01 idle, 0x02 fetch, 0x04 waiting for transmit data, 0x08 shifting out, 0x10 starting an input byte, 0x20 shifting in.
- R2: Opcode 0x1n with n from 1 to NUM_CS drives cs_n[n-1] low and all other selects high. n = 0 deasserts every select. A stop opcode leaves the selects unchanged.
- R3: Opcode 0x3n sends n bytes on mosi, taking the transmit word from its top byte down. Timing is mode 0: sclk idles low, mosi changes after a falling edge, and data is sampled on the rising edge. The SCK period is 2*(div+1) clocks, where div is clock-configuration bits 63:52.
- R4: Writing the transmit word sets status bit 59. The bit clears when a shift-out opcode ends, or when all eight bytes of the word have been sent. A shift-out longer than eight bytes then waits in state 0x04 with sclk still until the word is rewritten. While waiting for data, status bit 57 is set.
- R5: A transmit write while bit 59 is set is discarded and sets sticky bit 58.
- R6: Opcode 0x4n receives n bytes while mosi is held low. The bytes are packed right-justified into the receive word, so the last byte lands in bits 7:0. Status bit 63 is set when the opcode ends.
- R7: Reading the receive word clears bit 63. Reading it while bit 63 is clear sets sticky bit 61. If a shift-in ends while bit 63 is set, sticky bit 62 is set and the old word is kept.
- R8: The following faults stop the program, deassert all selects and return the engine to idle. A shift-in before any shift-out sets bit 22. A shift-in of more than MAX_IN bytes sets bit 23. Any other opcode (copy, branch, unknown) sets bit 21.
- R9: A clock-configuration write with bits 36 and 38 set arms an abort. A directly following configuration write with bits 37 and 39 set then aborts the engine: it goes idle, all selects are released, and both full flags clear. The second pattern alone does nothing. Any status write clears bits 21-23, 57, 58, 61 and 62.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe (pops the receive word) |
| host_addr | input | 3 | Register address |
| host_wdata | input | 64 | Write data |
| host_rdata | output | 64 | Read data, combinational from host_addr |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The hardest state to reach is a shift-out that stalls partway through a single opcode. The bench programs a twelve-byte shift-out and supplies only one transmit word. It polls the full flag until it drops, then holds back the second word for a while. During that gap it checks the waiting state, the underrun flag, the held select and the quiet clock. The same stalled state is then reused to show that an unarmed abort pattern is ignored and that the armed pair aborts. A slave model in the bench shifts known bytes back so that the receive packing and the overrun ordering can be checked.

// File: rtl/seqspi_pkg.sv
package seqspi_pkg;
   localparam int WORD_W = 64;
   localparam int BYTES  = WORD_W / 8;
   localparam int DIV_W  = 12;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_PROG = 3'd0;
   localparam logic [ADDR_W-1:0] A_CLK  = 3'd1;
   localparam logic [ADDR_W-1:0] A_TXD  = 3'd2;
   localparam logic [ADDR_W-1:0] A_RXD  = 3'd3;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

   // status bit positions
   localparam int SB_RXFULL = 63;
   localparam int SB_RXOVR  = 62;
   localparam int SB_RXUND  = 61;
   localparam int SB_TXFULL = 59;
   localparam int SB_TXOVR  = 58;
   localparam int SB_TXUND  = 57;
   localparam int SB_STLO   = 48;
   localparam int SB_ERRLO  = 21;

   typedef enum logic [7:0] {
      S_IDLE  = 8'h01,
      S_FETCH = 8'h02,
      S_OWAIT = 8'h04,
      S_ORUN  = 8'h08,
      S_IGO   = 8'h10,
      S_IRUN  = 8'h20
   } seq_st_t;
endpackage

// File: rtl/seqspi_bitshift.sv
module seqspi_bitshift #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort,
   input  logic             start,
   input  logic [7:0]       tx_byte,
   input  logic [DIV_W-1:0] div,
   input  logic             miso,
   output logic             sclk,
   output logic             mosi,
   output logic             busy,
   output logic             done,
   output logic [7:0]       rx_byte
);
   logic [DIV_W-1:0] tick;
   logic [2:0]       bits;
   logic [7:0]       sh;
   logic [7:0]       rsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick <= '0;
         bits <= '0;
         sh   <= '0;
         rsh  <= '0;
         sclk <= 1'b0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (abort) begin
            busy <= 1'b0;
            sclk <= 1'b0;
            tick <= '0;
            sh   <= '0;
         end else if (start && !busy) begin
            busy <= 1'b1;
            sh   <= tx_byte;
            tick <= '0;
            bits <= '0;
            sclk <= 1'b0;
         end else if (busy) begin
            if (tick == div) begin
               tick <= '0;
               if (!sclk) begin
                  sclk <= 1'b1;
                  rsh  <= {rsh[6:0], miso};
               end else begin
                  sclk <= 1'b0;
                  if (bits == 3'd7) begin
                     busy <= 1'b0;
                     done <= 1'b1;
                     sh   <= '0;
                  end else begin
                     bits <= bits + 3'd1;
                     sh   <= {sh[6:0], 1'b0};
                  end
               end
            end else begin
               tick <= tick + 1'b1;
            end
         end
      end
   end

   assign mosi    = sh[7];
   assign rx_byte = rsh;
endmodule

// File: rtl/seqspi_csdec.sv
module seqspi_csdec #(
   parameter int NUM_CS = 4
) (
   input  logic [3:0]        sel,
   output logic [NUM_CS-1:0] cs_n
);
   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs_n[i] = (sel != 4'(i + 1));
   end
endmodule

// File: rtl/seqspi_rxreg.sv
module seqspi_rxreg #(
   parameter int WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              clr_flags,
   input  logic              acc_clr,
   input  logic              push,
   input  logic              last,
   input  logic [7:0]        byte_in,
   input  logic              pop,
   output logic [WORD_W-1:0] word,
   output logic              full,
   output logic              ovr,
   output logic              und
);
   logic [WORD_W-1:0] acc;
   logic [WORD_W-1:0] acc_nx;

   assign acc_nx = {acc[WORD_W-9:0], byte_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         word <= '0;
         full <= 1'b0;
         ovr  <= 1'b0;
         und  <= 1'b0;
      end else begin
         if (flush) begin
            acc  <= '0;
            full <= 1'b0;
         end else begin
            if (acc_clr)   acc <= '0;
            else if (push) acc <= acc_nx;
            if (pop && !full) und <= 1'b1;
            if (push && last) begin
               if (full && !pop) ovr <= 1'b1;
               else begin
                  word <= acc_nx;
                  full <= 1'b1;
               end
            end else if (pop) begin
               full <= 1'b0;
            end
         end
         if (clr_flags) begin
            ovr <= 1'b0;
            und <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/seqspi_engine.sv
module seqspi_engine
   import seqspi_pkg::*;
#(
   parameter int NUM_CS = 4,
   parameter int MAX_IN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_re,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_n
);
   if (NUM_CS < 1 || NUM_CS > 15) begin : g_bad_cs
      $error("NUM_CS must be 1..15");
   end
   if (MAX_IN < 1 || MAX_IN > BYTES) begin : g_bad_in
      $error("MAX_IN must be 1..BYTES");
   end

   seq_st_t           st;
   logic [WORD_W-1:0] prog_q;
   logic [WORD_W-1:0] cfg_q;
   logic [WORD_W-1:0] tx_word;
   logic              tx_full;
   logic [2:0]        tx_idx;
   logic [3:0]        cs_sel;
   logic [3:0]        cnt;
   logic              did_out;
   logic              armed;
   logic              tx_ovr;
   logic              tx_und;
   logic [2:0]        err;

   logic [7:0] op;
   logic       wr_cfg, wr_stat, wr_tx, step1, step2, soft_rst;
   logic       sh_start, sh_done, sh_busy;
   logic [7:0] sh_tx, sh_rx;
   logic       rx_push, rx_last, rx_commit, rx_pop, acc_clr;
   logic       rx_full, rx_ovr, rx_und;
   logic [WORD_W-1:0] rx_word;
   logic [WORD_W-1:0] stat_w;

   assign op       = prog_q[WORD_W-1 -: 8];
   assign wr_cfg   = host_we && (host_addr == A_CLK);
   assign wr_stat  = host_we && (host_addr == A_STAT);
   assign wr_tx    = host_we && (host_addr == A_TXD);
   assign step1    = (host_wdata[39:36] == 4'b0101);
   assign step2    = (host_wdata[39:36] == 4'b1010);
   assign soft_rst = wr_cfg && step2 && armed;

   assign sh_start  = ((st == S_OWAIT) && tx_full) || (st == S_IGO);
   assign sh_tx     = (st == S_OWAIT) ? tx_word[8*(7-tx_idx) +: 8] : 8'h00;
   assign rx_push   = (st == S_IRUN) && sh_done;
   assign rx_last   = (cnt == 4'd1);
   assign rx_commit = rx_push && rx_last;
   assign rx_pop    = host_re && (host_addr == A_RXD);
   assign acc_clr   = (st == S_FETCH) && (op[7:4] == 4'h4);

   seqspi_bitshift #(.DIV_W(DIV_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .abort   (soft_rst),
      .start   (sh_start),
      .tx_byte (sh_tx),
      .div     (cfg_q[WORD_W-1 -: DIV_W]),
      .miso    (miso),
      .sclk    (sclk),
      .mosi    (mosi),
      .busy    (sh_busy),
      .done    (sh_done),
      .rx_byte (sh_rx)
   );

   seqspi_rxreg #(.WORD_W(WORD_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (soft_rst),
      .clr_flags (wr_stat),
      .acc_clr   (acc_clr),
      .push      (rx_push),
      .last      (rx_last),
      .byte_in   (sh_rx),
      .pop       (rx_pop),
      .word      (rx_word),
      .full      (rx_full),
      .ovr       (rx_ovr),
      .und       (rx_und)
   );

   seqspi_csdec #(.NUM_CS(NUM_CS)) u_cs (
      .sel  (cs_sel),
      .cs_n (cs_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         prog_q  <= '0;
         cfg_q   <= '0;
         tx_word <= '0;
         tx_full <= 1'b0;
         tx_idx  <= '0;
         cs_sel  <= '0;
         cnt     <= '0;
         did_out <= 1'b0;
         armed   <= 1'b0;
         tx_ovr  <= 1'b0;
         tx_und  <= 1'b0;
         err     <= '0;
      end else begin
         if (wr_cfg) begin
            cfg_q <= host_wdata;
            armed <= step1;
         end
         if (soft_rst) begin
            st      <= S_IDLE;
            cs_sel  <= '0;
            tx_full <= 1'b0;
            tx_idx  <= '0;
         end else begin
            case (st)
               S_IDLE: if (host_we && host_addr == A_PROG) begin
                  prog_q  <= host_wdata;
                  did_out <= 1'b0;
                  st      <= S_FETCH;
               end
               S_FETCH: begin
                  prog_q <= prog_q << 8;
                  case (op[7:4])
                     4'h0: begin
                        if (op[3:0] != 4'h0) begin
                           err[0] <= 1'b1;
                           cs_sel <= '0;
                        end
                        st <= S_IDLE;
                     end
                     4'h1: cs_sel <= op[3:0];
                     4'h3: if (op[3:0] != 4'h0) begin
                        cnt     <= op[3:0];
                        did_out <= 1'b1;
                        st      <= S_OWAIT;
                     end
                     4'h4: begin
                        if (!did_out) begin
                           err[1] <= 1'b1;
                           cs_sel <= '0;
                           st     <= S_IDLE;
                        end else if (op[3:0] > 4'(MAX_IN)) begin
                           err[2] <= 1'b1;
                           cs_sel <= '0;
                           st     <= S_IDLE;
                        end else if (op[3:0] != 4'h0) begin
                           cnt <= op[3:0];
                           st  <= S_IGO;
                        end
                     end
                     default: begin
                        err[0] <= 1'b1;
                        cs_sel <= '0;
                        st     <= S_IDLE;
                     end
                  endcase
               end
               S_OWAIT: begin
                  if (tx_full) st <= S_ORUN;
                  else         tx_und <= 1'b1;
               end
               S_ORUN: if (sh_done) begin
                  cnt <= cnt - 4'd1;
                  if (cnt == 4'd1) begin
                     tx_full <= 1'b0;
                     tx_idx  <= '0;
                     st      <= S_FETCH;
                  end else if (tx_idx == 3'd7) begin
                     tx_full <= 1'b0;
                     tx_idx  <= '0;
                     st      <= S_OWAIT;
                  end else begin
                     tx_idx <= tx_idx + 3'd1;
                     st     <= S_OWAIT;
                  end
               end
               S_IGO: st <= S_IRUN;
               S_IRUN: if (sh_done) begin
                  cnt <= cnt - 4'd1;
                  st  <= (cnt == 4'd1) ? S_FETCH : S_IGO;
               end
               default: st <= S_IDLE;
            endcase
         end
         if (wr_tx) begin
            if (tx_full) tx_ovr <= 1'b1;
            else if (!soft_rst) begin
               tx_word <= host_wdata;
               tx_full <= 1'b1;
            end
         end
         if (wr_stat) begin
            tx_ovr <= 1'b0;
            tx_und <= 1'b0;
            err    <= '0;
         end
      end
   end

   always_comb begin
      stat_w = '0;
      stat_w[SB_RXFULL] = rx_full;
      stat_w[SB_RXOVR]  = rx_ovr;
      stat_w[SB_RXUND]  = rx_und;
      stat_w[SB_TXFULL] = tx_full;
      stat_w[SB_TXOVR]  = tx_ovr;
      stat_w[SB_TXUND]  = tx_und;
      stat_w[SB_STLO +: 8]  = st;
      stat_w[SB_ERRLO +: 3] = err;
   end

   always_comb begin
      case (host_addr)
         A_PROG:  host_rdata = prog_q;
         A_CLK:   host_rdata = cfg_q;
         A_TXD:   host_rdata = tx_word;
         A_RXD:   host_rdata = rx_word;
         A_STAT:  host_rdata = stat_w;
         default: host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/seqspi_checker.sv
module seqspi_checker
   import seqspi_pkg::*;
#(
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic              host_re,
   input logic [ADDR_W-1:0] host_addr,
   input logic [NUM_CS-1:0] cs_n,
   input logic              sclk,
   input logic [7:0]        st,
   input logic              tx_full,
   input logic              tx_ovr,
   input logic              rx_full,
   input logic              rx_commit,
   input logic              did_out
);
   assert_state_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(st));

   assert_cs_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 8'h01) |-> !sclk);

   assert_tx_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == A_TXD && tx_full) |=> tx_ovr);

   assert_rx_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_re && host_addr == A_RXD && rx_full && !rx_commit) |=> !rx_full);

   assert_in_after_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 8'h10) |-> did_out);
endmodule

bind seqspi_engine seqspi_checker #(.NUM_CS(NUM_CS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_we   (host_we),
   .host_re   (host_re),
   .host_addr (host_addr),
   .cs_n      (cs_n),
   .sclk      (sclk),
   .st        (st),
   .tx_full   (tx_full),
   .tx_ovr    (tx_ovr),
   .rx_full   (rx_full),
   .rx_commit (rx_commit),
   .did_out   (did_out)
);

// File: tb/sim_seqspi_engine.sv
module sim_seqspi_engine;
   localparam int CLK_PERIOD = 10;
   localparam int NCS = 4;

   typedef struct packed {
      logic [7:0]     b;
      logic [NCS-1:0] cs;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_we = 1'b0;
   logic host_re = 1'b0;
   logic [2:0] host_addr = 3'd0;
   logic [63:0] host_wdata = '0;
   logic [63:0] host_rdata;
   logic sclk, mosi, miso;
   logic [NCS-1:0] cs_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   seqspi_engine #(.NUM_CS(NCS), .MAX_IN(8)) u0 (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

   // slave model: drives miso from a preloaded shift register
   logic [127:0] slv;
   logic [127:0] slv_init = '0;
   logic slv_ld = 1'b0;
   assign miso = slv[127];
   always @(negedge sclk or posedge slv_ld) begin
      if (slv_ld) slv <= slv_init;
      else        slv <= slv << 1;
   end

   // scoreboard: driver pushes, monitor consumes via its own index
   item_t exp_q[$];
   int mon_idx = 0;
   int mon_cmp = 0;
   int mon_bad = 0;
   int mon_n = 0;
   logic [7:0] mon_sh = '0;
   always @(posedge sclk) begin
      mon_sh = {mon_sh[6:0], mosi};
      mon_n++;
      if (mon_n == 8) begin
         mon_n = 0;
         mon_cmp++;
         if (mon_idx >= exp_q.size()) begin
            mon_bad++;
            $display("FAIL R3 unexpected byte act=%h exp=none", mon_sh);
         end else begin
            if (mon_sh !== exp_q[mon_idx].b || cs_n !== exp_q[mon_idx].cs) begin
               mon_bad++;
               $display("FAIL R3/R2 byte %0d act=%h cs=%b exp=%h cs=%b",
                        mon_idx, mon_sh, cs_n, exp_q[mon_idx].b, exp_q[mon_idx].cs);
            end
            mon_idx++;
         end
      end
   end

   int n_cmp = 0;
   int n_bad = 0;

   task automatic report(input int extra);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
               n_cmp + mon_cmp + extra, n_bad + mon_bad + extra);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      $display("FAIL watchdog act=running exp=finished");
      report(1);
      $finish;
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b, input logic [NCS-1:0] cs);
      exp_q.push_back({b, cs});
   endtask

   task automatic wr(input logic [2:0] a, input logic [63:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [63:0] d);
      @(negedge clk);
      host_addr = a; host_re = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_re = 1'b0;
   endtask

   task automatic peek(output logic [63:0] d);
      @(negedge clk);
      host_addr = 3'd4;
      #1 d = host_rdata;
   endtask

   task automatic wait_idle(input string tag);
      logic [63:0] s;
      for (int i = 0; i < 20000; i++) begin
         peek(s);
         if (s[55:48] == 8'h01) return;
      end
      check(tag, s[55:48], 64'h01);
   endtask

   task automatic wait_tx_taken(input string tag);
      logic [63:0] s;
      for (int i = 0; i < 20000; i++) begin
         peek(s);
         if (!s[59]) return;
      end
      check(tag, s[59], 64'h0);
   endtask

   task automatic load_slave(input logic [127:0] v);
      slv_init = v;
      #1 slv_ld = 1'b1;
      #1 slv_ld = 1'b0;
   endtask

   logic [63:0] s, d;
   time t0, t1;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      peek(s);
      check("R1 reset status", s, 64'h0001_0000_0000_0000);
      check("R2 reset selects", 64'(cs_n), 64'hF);
      check("R3 reset sclk", 64'(sclk), 64'h0);

      // R1/R2/R3 basic shift-out with divider 2
      wr(3'd1, 64'h0020_0000_0000_0000);
      push(8'hA5, 4'b1110);
      push(8'hC3, 4'b1110);
      wr(3'd0, {8'h11, 8'h32, 48'h0});
      wr(3'd2, 64'hA5C3_0000_0000_0000);
      @(posedge sclk); t0 = $time;
      @(posedge sclk); t1 = $time;
      check("R3 sck period", 64'((t1 - t0) / CLK_PERIOD), 64'd6);
      wait_idle("R1 idle after stop");
      peek(s);
      check("R4 full cleared at end", s[59], 64'h0);
      check("R2 stop keeps select", 64'(cs_n), 64'hE);
      wr(3'd0, {8'h10, 56'h0});
      wait_idle("R1 idle");
      check("R2 deselect all", 64'(cs_n), 64'hF);

      // R1: eight selects, no stop opcode
      wr(3'd0, 64'h1112_1314_1112_1314);
      wait_idle("R1 eight slots end");
      check("R1 last of eight slots", 64'(cs_n), 64'h7);

      // R4: twelve-byte shift-out stalls after first word
      wr(3'd1, 64'h0010_0000_0000_0000);
      for (int i = 1; i <= 12; i++) push(8'(i), 4'b1101);
      wr(3'd0, {8'h12, 8'h3C, 8'h10, 40'h0});
      wr(3'd2, 64'h0102_0304_0506_0708);
      wait_tx_taken("R4 first word taken");
      repeat (50) @(negedge clk);
      peek(s);
      check("R4 stalled state", s[55:48], 64'h04);
      check("R4 underrun flag", s[57], 64'h1);
      check("R4 stall holds select", 64'(cs_n), 64'hD);
      check("R4 stall sclk quiet", 64'(sclk), 64'h0);
      wr(3'd2, 64'h090A_0B0C_0000_0000);
      wait_idle("R4 finish");
      check("R4 deselect after", 64'(cs_n), 64'hF);

      // R5: overrun on transmit
      wr(3'd4, 64'h0);
      wr(3'd2, 64'h1111_1111_1111_1111);
      wr(3'd2, 64'h2222_2222_2222_2222);
      peek(s);
      check("R5 tx overrun flag", s[58], 64'h1);
      rd(3'd2, d);
      check("R5 second write dropped", d, 64'h1111_1111_1111_1111);
      wr(3'd4, 64'h0);
      peek(s);
      check("R9 status write clears overrun", s[58], 64'h0);
      push(8'h11, 4'b1011);
      wr(3'd0, {8'h13, 8'h31, 8'h10, 40'h0});
      wait_idle("R5 run");

      // R6/R7: shift-in packing
      load_slave({8'h00, 8'h12, 8'h34, 8'h56, 96'h0});
      push(8'h5A, 4'b1110);
      for (int i = 0; i < 3; i++) push(8'h00, 4'b1110);
      wr(3'd0, {8'h11, 8'h31, 8'h43, 8'h10, 32'h0});
      wr(3'd2, 64'h5A00_0000_0000_0000);
      wait_idle("R6 run");
      peek(s);
      check("R6 rx full set", s[63], 64'h1);
      rd(3'd3, d);
      check("R6 right-justified word", d, 64'h0000_0000_0012_3456);
      peek(s);
      check("R7 read clears full", s[63], 64'h0);
      rd(3'd3, d);
      peek(s);
      check("R7 empty read underrun", s[61], 64'h1);

      // R7: overrun keeps the old word
      wr(3'd4, 64'h0);
      load_slave({8'h00, 8'hAB, 8'hCD, 104'h0});
      push(8'h77, 4'b1110); push(8'h00, 4'b1110); push(8'h00, 4'b1110);
      wr(3'd0, {8'h11, 8'h31, 8'h42, 8'h10, 32'h0});
      wr(3'd2, 64'h7700_0000_0000_0000);
      wait_idle("R7 first");
      load_slave({8'h00, 8'hEF, 112'h0});
      push(8'h66, 4'b1110); push(8'h00, 4'b1110);
      wr(3'd0, {8'h11, 8'h31, 8'h41, 8'h10, 32'h0});
      wr(3'd2, 64'h6600_0000_0000_0000);
      wait_idle("R7 second");
      peek(s);
      check("R7 rx overrun flag", s[62], 64'h1);
      rd(3'd3, d);
      check("R7 old word kept", d, 64'h0000_0000_0000_ABCD);

      // R8: program faults
      wr(3'd4, 64'h0);
      wr(3'd0, {8'h11, 8'h42, 48'h0});
      wait_idle("R8 order");
      peek(s);
      check("R8 shift-in first flag", s[23:21], 64'h2);
      check("R8 selects released", 64'(cs_n), 64'hF);
      wr(3'd4, 64'h0);
      push(8'h44, 4'b1110);
      wr(3'd0, {8'h11, 8'h31, 8'h49, 40'h0});
      wr(3'd2, 64'h4400_0000_0000_0000);
      wait_idle("R8 length");
      peek(s);
      check("R8 long shift-in flag", s[23:21], 64'h4);
      check("R8 selects released 2", 64'(cs_n), 64'hF);
      wr(3'd4, 64'h0);
      wr(3'd0, {8'h11, 8'hC0, 48'h0});
      wait_idle("R8 unsupported");
      peek(s);
      check("R8 unsupported opcode flag", s[23:21], 64'h1);

      // R9: two-step abort
      wr(3'd4, 64'h0);
      for (int i = 0; i < 8; i++) push(8'h81 + 8'(i), 4'b1110);
      wr(3'd0, {8'h11, 8'h3C, 48'h0});
      wr(3'd2, 64'h8182_8384_8586_8788);
      wait_tx_taken("R9 stall reached");
      repeat (10) @(negedge clk);
      wr(3'd1, 64'h0010_00A0_0000_0000);
      peek(s);
      check("R9 unarmed pattern ignored", s[55:48], 64'h04);
      check("R9 unarmed keeps select", 64'(cs_n), 64'hE);
      wr(3'd1, 64'h0010_0050_0000_0000);
      wr(3'd1, 64'h0010_00A0_0000_0000);
      peek(s);
      check("R9 abort to idle", s[55:48], 64'h01);
      check("R9 abort releases selects", 64'(cs_n), 64'hF);
      wr(3'd2, 64'hDEAD_0000_0000_0000);
      wr(3'd1, 64'h0010_0050_0000_0000);
      wr(3'd1, 64'h0010_00A0_0000_0000);
      peek(s);
      check("R9 abort clears tx full", s[59], 64'h0);
      wr(3'd4, 64'h0);
      peek(s);
      check("R9 clean status", s, 64'h0001_0000_0000_0000);

      check("R3 all expected bytes seen", 64'(mon_idx), 64'(exp_q.size()));
      report(0);
      $finish;
   end
endmodule